// File: doc/BRIEF.md
# Stepped Power-Amplifier Ramp Controller

This block drives the 6-bit output-power code of a transmit amplifier. It walks the code toward a goal one level at a time, so that turning the transmitter on or off never produces an abrupt jump that would splatter energy into neighbouring channels. The goal is the programmed target level while both the direct enable and the transmit request are high, and zero otherwise.

The pace is set by a 3-bit rate field. Each setting allows a fixed count of single-level steps in one data-bit period, from 1 to 128 in powers of two. The steps are spread evenly over the period by a phase counter that runs on the fast clock and is restarted by a once-per-bit tick. The two control paths behave differently. Dropping the transmit request ramps the code down at the programmed pace. Dropping the direct enable clears the code at once. A done flag is high whenever the code has reached its current goal.

Top module: `pa_ramp_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the PA code is 0 and the done flag is 1.
- R2: While the direct enable is high, the code changes by at most one level per clock, so a full ramp from 0 to 63 shows all 64 code values.
- R3: The phase counter restarts on each bit tick. With `CYC_PER_BIT` clocks between ticks and rate select r, exactly 2^r steps fall in one period, starting from the cycle after the tick. For r = 0 to 5, a ramp from 0 reaches code 2^r one period after it starts.
- R4: The code changes only on a step slot or on a forced clear.
- R5: When the direct enable is sampled low, the code is 0 one clock later.
- R6: With both enable and transmit request high, the code climbs one level per step slot and stops at the target without overshoot.
- R7: Dropping the transmit request while the enable stays high ramps the code down to 0 at the programmed pace rather than clearing it.
- R8: If the target is lowered below the current code while active, the code steps down to the new target one level per step slot.
- R9: The done flag is 1 exactly when the code equals the goal: the target while enable and request are both high, and 0 otherwise.
- R10: Bit ticks that arrive more often than the step interval keep resetting the phase counter, so no step slot occurs. At rate 0 with ticks every 100 clocks, the code stays at 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_en | input | 1 | Direct amplifier enable; low clears the code at once |
| tx_req | input | 1 | Transmit request; toggling it ramps up or down |
| target_lvl | input | 6 | Programmed target power code |
| rate_sel | input | 3 | Ramp pace; 2^rate_sel steps per bit period |
| bit_tick | input | 1 | One-clock pulse at the start of each data-bit period |
| pa_code | output | 6 | Current amplifier power code |
| ramp_done | output | 1 | Code equals its current goal |

## Verification
A ramp from zero at each rate from 0 to 5 is checked after one exact period, which separates a correct step count from an off-by-one or a wrong shift. The fastest rate is run through the whole code range to show that no level is skipped. Turning off through the transmit request and turning off through the enable are compared with each other, which isolates the asymmetric shutdown. Lowering the target mid-ramp shows downward stepping toward a non-zero goal. Ticks spaced shorter than the step interval show that the phase counter restarts on every tick.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;

    localparam int CODE_W = 6;

    typedef logic [CODE_W-1:0] pa_code_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_e;

    // Per-cycle command derived from the two control paths
    typedef struct packed {
        pa_code_t goal;
        logic     force_off;
    } ramp_cmd_t;

    function automatic ramp_dir_e step_dir(input pa_code_t cur, input pa_code_t goal);
        if (cur < goal) return DIR_UP;
        if (cur > goal) return DIR_DOWN;
        return DIR_HOLD;
    endfunction

endpackage

// File: rtl/pa_ramp_pacer.sv
module pa_ramp_pacer #(
    parameter int CYC_PER_BIT = 256,
    parameter int RATE_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              step_stb
);
    localparam int CW = $clog2(CYC_PER_BIT);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] slot_mask;
    int            interval;

    // Step interval in clocks = period / 2^rate, never below one
    always_comb begin
        interval = CYC_PER_BIT >> rate_sel;
        if (interval < 1) interval = 1;
        slot_mask = CW'(interval - 1);
    end

    assign step_stb = (phase_q & slot_mask) == slot_mask;

    always_ff @(posedge clk) begin
        if (rst)           phase_q <= '0;
        else if (bit_tick) phase_q <= '0;
        else               phase_q <= phase_q + 1'b1;
    end

    // R3 / R10: the cycle after a tick is never a step slot when the interval exceeds one
    p_no_slot_after_tick_r10: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && ((CYC_PER_BIT >> rate_sel) > 1)) |=> (!step_stb || !$stable(rate_sel)));

endmodule

// File: rtl/pa_ramp_goal.sv
module pa_ramp_goal
    import pa_ramp_pkg::*;
(
    input  logic      pa_en,
    input  logic      tx_req,
    input  pa_code_t  target_lvl,
    output ramp_cmd_t cmd
);
    always_comb begin
        cmd.force_off = !pa_en;
        cmd.goal      = (pa_en && tx_req) ? target_lvl : '0;
    end
endmodule

// File: rtl/pa_ramp_stepper.sv
module pa_ramp_stepper
    import pa_ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ramp_cmd_t cmd,
    input  logic      step_stb,
    output pa_code_t  code_q,
    output logic      done
);
    ramp_dir_e dir;

    assign dir  = step_dir(code_q, cmd.goal);
    assign done = (dir == DIR_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (cmd.force_off) begin
            code_q <= '0;
        end else if (step_stb) begin
            case (dir)
                DIR_UP:   code_q <= code_q + 1'b1;
                DIR_DOWN: code_q <= code_q - 1'b1;
                default:  code_q <= code_q;
            endcase
        end
    end

    p_single_level_r2: assert property (@(posedge clk) disable iff (rst)
        !cmd.force_off |=> (code_q == $past(code_q)) ||
                           (code_q == CODE_W'($past(code_q) + 1'b1)) ||
                           (code_q == CODE_W'($past(code_q) - 1'b1)));

    p_hold_between_slots_r4: assert property (@(posedge clk) disable iff (rst)
        (!step_stb && !cmd.force_off) |=> $stable(code_q));

    p_clear_now_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.force_off |=> (code_q == '0));

    p_climb_r6: assert property (@(posedge clk) disable iff (rst)
        (step_stb && !cmd.force_off && (code_q < cmd.goal))
            |=> (code_q == CODE_W'($past(code_q) + 1'b1)));

    p_descend_r8: assert property (@(posedge clk) disable iff (rst)
        (step_stb && !cmd.force_off && (code_q > cmd.goal))
            |=> (code_q == CODE_W'($past(code_q) - 1'b1)));

endmodule

// File: rtl/pa_ramp_ctrl.sv
module pa_ramp_ctrl
    import pa_ramp_pkg::*;
#(
    parameter int CYC_PER_BIT = 256,
    parameter int RATE_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pa_en,
    input  logic              tx_req,
    input  logic [5:0]        target_lvl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              bit_tick,
    output logic [5:0]        pa_code,
    output logic              ramp_done
);
    ramp_cmd_t cmd;
    logic      step_stb;
    pa_code_t  code_q;

    pa_ramp_pacer #(
        .CYC_PER_BIT (CYC_PER_BIT),
        .RATE_W      (RATE_W)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .rate_sel (rate_sel),
        .step_stb (step_stb)
    );

    pa_ramp_goal u_goal (
        .pa_en      (pa_en),
        .tx_req     (tx_req),
        .target_lvl (target_lvl),
        .cmd        (cmd)
    );

    pa_ramp_stepper u_stepper (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .step_stb (step_stb),
        .code_q   (code_q),
        .done     (ramp_done)
    );

    assign pa_code = code_q;

    // R9: done while active means the code sits on the programmed target
    p_done_at_target_r9: assert property (@(posedge clk) disable iff (rst)
        (pa_en && tx_req && ramp_done) |-> (pa_code == target_lvl));

    // R7: losing only the transmit request never clears the code in one cycle
    p_soft_off_r7: assert property (@(posedge clk) disable iff (rst)
        (pa_en && !tx_req && (pa_code > 6'd1)) |=> (!pa_en || (pa_code != 6'd0)));

endmodule

// File: tb/pa_ramp_ctrl_tb_top.sv
module pa_ramp_ctrl_tb_top;
    localparam int CYC = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pa_en = 1'b0;
    logic       tx_req = 1'b0;
    logic [5:0] target_lvl = '0;
    logic [2:0] rate_sel = '0;
    logic       bit_tick = 1'b0;
    logic [5:0] pa_code;
    logic       ramp_done;

    always #5 clk = ~clk;

    pa_ramp_ctrl #(.CYC_PER_BIT(CYC), .RATE_W(3)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pa_en      (pa_en),
        .tx_req     (tx_req),
        .target_lvl (target_lvl),
        .rate_sel   (rate_sel),
        .bit_tick   (bit_tick),
        .pa_code    (pa_code),
        .ramp_done  (ramp_done)
    );

    int    checks = 0;
    int    fails = 0;
    int    tc = 0;
    int    per = CYC;
    string cur_req = "R1";
    bit    finished = 0;
    bit    cmp_on = 0;
    logic [63:0] seen = '0;

    // Behavioural reference: integer phase and code
    int m_code = 0;
    int m_ph = 0;
    int m_iv, m_goal;
    bit m_stb;

    always @(posedge clk) begin
        if (rst) begin
            m_code = 0;
            m_ph = 0;
        end else begin
            m_iv = CYC / (1 << rate_sel);
            if (m_iv < 1) m_iv = 1;
            m_goal = (pa_en && tx_req) ? int'(target_lvl) : 0;
            m_stb = ((m_ph % m_iv) == m_iv - 1);
            if (!pa_en) m_code = 0;
            else if (m_stb && m_code < m_goal) m_code = m_code + 1;
            else if (m_stb && m_code > m_goal) m_code = m_code - 1;
            m_ph = bit_tick ? 0 : (m_ph + 1) % CYC;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the reference every cycle
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            int g;
            g = (pa_en && tx_req) ? int'(target_lvl) : 0;
            chk(cur_req, int'(pa_code), m_code);
            chk("R9", int'(ramp_done), (m_code == g) ? 1 : 0);
            seen[pa_code] = 1'b1;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        bit_tick = (per > 0) && ((tc % per) == 0);
        tc++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(2_000_000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        steps(3);
        chk("R1", int'(pa_code), 0);
        chk("R1", int'(ramp_done), 1);
        rst = 1'b0;
        step();
        chk("R1", int'(pa_code), 0);
        chk("R1", int'(ramp_done), 1);
        cmp_on = 1;

        // R6: ramp up to 40 at rate 2, done low mid-ramp
        cur_req = "R6";
        rate_sel = 3'd2; target_lvl = 6'd40; pa_en = 1; tx_req = 1;
        steps(500);
        chk("R9", int'(ramp_done), 0);
        steps(2700);
        chk("R6", int'(pa_code), 40);
        chk("R9", int'(ramp_done), 1);

        // R8: lower target, code steps down to it
        cur_req = "R8";
        target_lvl = 6'd10;
        steps(2400);
        chk("R8", int'(pa_code), 10);

        // R7: drop transmit request, soft ramp down
        cur_req = "R7";
        tx_req = 0;
        step();
        chk("R7", (pa_code >= 6'd9) ? 1 : 0, 1);
        steps(2900);
        chk("R7", int'(pa_code), 0);
        chk("R7", int'(ramp_done), 1);

        // R2: fastest rate through the full range
        cur_req = "R2";
        rate_sel = 3'd7; target_lvl = 6'd63; tx_req = 1;
        seen = '0;
        steps(300);
        chk("R2", int'(pa_code), 63);
        chk("R2", $countones(seen), 64);

        // R5: dropping the enable clears at once
        cur_req = "R5";
        pa_en = 0;
        step();
        chk("R5", int'(pa_code), 0);

        // R3: one period of ramp gives 2^r levels
        cur_req = "R3";
        for (int r = 0; r < 6; r++) begin
            pa_en = 0; tx_req = 0; rate_sel = 3'(r);
            step();
            while ((tc % per) != 0) step();
            step();                       // tick sampled, enable still low
            pa_en = 1; tx_req = 1;
            steps(CYC);
            chk("R3", int'(pa_code), 1 << r);
        end

        // R10: ticks shorter than the step interval block every slot
        cur_req = "R10";
        pa_en = 0; tx_req = 0; rate_sel = 3'd0; per = 100;
        step();
        while ((tc % per) != 0) step();
        step();
        pa_en = 1; tx_req = 1;
        steps(600);
        chk("R10", int'(pa_code), 0);

        // R4: with regular ticks again the slow ramp resumes
        cur_req = "R4";
        per = CYC;
        steps(600);
        chk("R4", (pa_code >= 6'd1 && pa_code <= 6'd3) ? 1 : 0, 1);

        finished = 1;
        cmp_on = 0;
        summary();
        $finish;
    end
endmodule